// File: doc/BRIEF.md
# Dual-PLL Entropy Source Configuration Checker

This block judges one candidate setting for an entropy source built from two phase-locked loops. Each loop has a feedback multiplier, a reference pre-divider and an output post-divider. The block takes the six coefficients through a start/ready handshake. It forms the two global coefficients, a product KM = M1·N0·C0 and a product KD = M0·N1·C1. It then tests the candidate against the rules for coherent sampling and against the frequency windows of both loops. It returns pass or fail, together with a code that names the first rule that was broken.

All frequency bounds and the reference frequency are register inputs in integer units. Every ratio test is done by cross-multiplication, with products wide enough that no overflow can occur, so the block has no divider. The cheap tests all run together in one cycle. The iterative coprimality test starts only after every one of them has passed. A host can therefore sweep many candidates quickly, because most rejected ones cost a single cycle.

Top module: `pll_cfg_checker`

## Requirements
- R1: `ready_o` is high while idle. A `start_i` seen with `ready_o` high captures all coefficient and limit inputs, and `ready_o` then stays low until the result. A `start_i` seen while busy is ignored and does not change the result, `km_o` or `kd_o`.
- R2: On completion, `km_o` equals M1·N0·C0 and `kd_o` equals M0·N1·C1 of the captured candidate.
- R3: If any of the six coefficients is zero, the code is 1.
- R4: If M0, N1 or C1 is even, the code is 2, so a passing candidate always has an odd KD.
- R5: KD ≥ 500 gives code 3, and KM ≥ 1000 gives code 4. KD = 499 and KM = 999 are accepted.
- R6: For PLL0, all three window tests are strict. The code is 5 unless pfd_min < fref/N0 < pfd_max. The code is 6 unless vco_min < fref·M0/N0 < vco_max. The code is 7 unless out_min < fref·M0/(C0·N0) < out_max.
- R7: The same three tests are applied to PLL1, with codes 8, 9 and 10.
- R8: The code is 11 unless fref·M0/(C0·N0) < fmax. The output of PLL1 is not compared with fmax.
- R9: If every other test passes and gcd(KM, KD) ≠ 1, the code is 12. Otherwise the code is 0 and `pass_o` is 1.
- R10: When several rules are broken, the lowest code is reported. A failure with codes 1 to 11 raises `done_o` at the first clock edge after the accepting edge. The GCD runs only when none of those rules is broken.
- R11: `done_o` is a one-cycle pulse. On that pulse, `pass_o` is 1 exactly when the code is 0. The busy time never exceeds 2·KW+3 cycles, where KW is the width of the global coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to check the candidate on the inputs |
| m0_i | input | CW | PLL0 feedback multiplier |
| n0_i | input | CW | PLL0 reference pre-divider |
| c0_i | input | CW | PLL0 output post-divider |
| m1_i | input | CW | PLL1 feedback multiplier |
| n1_i | input | CW | PLL1 reference pre-divider |
| c1_i | input | CW | PLL1 output post-divider |
| fref_i | input | FW | Reference frequency |
| pfd_min_i | input | FW | Phase detector frequency, lower exclusive bound |
| pfd_max_i | input | FW | Phase detector frequency, upper exclusive bound |
| vco_min_i | input | FW | Oscillator frequency, lower exclusive bound |
| vco_max_i | input | FW | Oscillator frequency, upper exclusive bound |
| out_min_i | input | FW | Loop output frequency, lower exclusive bound |
| out_max_i | input | FW | Loop output frequency, upper exclusive bound |
| fmax_i | input | FW | Design clock limit that applies to PLL0 output only |
| ready_o | output | 1 | Idle, able to accept a start |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Candidate accepted |
| code_o | output | 4 | First broken rule (0 when passing) |
| km_o | output | 3·CW | Global multiplication coefficient |
| kd_o | output | 3·CW | Global division coefficient |

## Verification
A wrong priority order or a bad cross-product term changes `code_o` on the strobe of the affected candidate. Such an error shows up one cycle after acceptance, because every non-GCD rule resolves in the first check cycle. A corrupted GCD operand or step shows up as a wrong verdict between code 0 and code 12, or as a busy period that exceeds the step bound. An accept path that leaks while busy shows up as a change in `km_o` or `kd_o` before the strobe.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  typedef enum logic [3:0] {
    FC_OK     = 4'd0,
    FC_ZERO   = 4'd1,
    FC_PARITY = 4'd2,
    FC_KD     = 4'd3,
    FC_KM     = 4'd4,
    FC_PFD0   = 4'd5,
    FC_VCO0   = 4'd6,
    FC_OUT0   = 4'd7,
    FC_PFD1   = 4'd8,
    FC_VCO1   = 4'd9,
    FC_OUT1   = 4'd10,
    FC_FMAX   = 4'd11,
    FC_GCD    = 4'd12
  } fail_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RANGE,
    ST_GCD
  } chk_state_e;
endpackage

// File: rtl/pll_ratio_chk.sv
module pll_ratio_chk #(
  parameter int CW = 10,
  parameter int FW = 16,
  localparam int PW = FW + 2*CW + 1
) (
  input  logic [CW-1:0] m_i,
  input  logic [CW-1:0] n_i,
  input  logic [CW-1:0] c_i,
  input  logic [FW-1:0] fref_i,
  input  logic [FW-1:0] pfd_min_i,
  input  logic [FW-1:0] pfd_max_i,
  input  logic [FW-1:0] vco_min_i,
  input  logic [FW-1:0] vco_max_i,
  input  logic [FW-1:0] out_min_i,
  input  logic [FW-1:0] out_max_i,
  output logic          pfd_ok_o,
  output logic          vco_ok_o,
  output logic          out_ok_o
);
  logic [PW-1:0] fr, fm, cn;
  logic [PW-1:0] pmin_n, pmax_n, vmin_n, vmax_n, omin_cn, omax_cn;

  // all windows compared as products: lo*den < num < hi*den
  always_comb begin
    fr      = PW'(fref_i);
    fm      = PW'(fref_i) * PW'(m_i);
    cn      = PW'(c_i) * PW'(n_i);
    pmin_n  = PW'(pfd_min_i) * PW'(n_i);
    pmax_n  = PW'(pfd_max_i) * PW'(n_i);
    vmin_n  = PW'(vco_min_i) * PW'(n_i);
    vmax_n  = PW'(vco_max_i) * PW'(n_i);
    omin_cn = PW'(out_min_i) * cn;
    omax_cn = PW'(out_max_i) * cn;
    pfd_ok_o = (pmin_n < fr) && (fr < pmax_n);
    vco_ok_o = (vmin_n < fm) && (fm < vmax_n);
    out_ok_o = (omin_cn < fm) && (fm < omax_cn);
  end
endmodule

// File: rtl/pll_gcd_unit.sv
module pll_gcd_unit #(
  parameter int W = 30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic         one_o
);
  logic         busy_q;
  logic [W-1:0] a_q, b_q;
  logic         term;

  // both even means a common factor of two: stop early
  assign term   = busy_q && ((a_q == '0) || (b_q == '0) || (!a_q[0] && !b_q[0]));
  assign done_o = term;
  assign one_o  = ((a_q == '0) && (b_q == W'(1))) || ((b_q == '0) && (a_q == W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      a_q    <= a_i;
      b_q    <= b_i;
    end else if (busy_q) begin
      if (term)             busy_q <= 1'b0;
      else if (!a_q[0])     a_q <= a_q >> 1;
      else if (!b_q[0])     b_q <= b_q >> 1;
      else if (a_q >= b_q)  a_q <= (a_q - b_q) >> 1;
      else                  b_q <= (b_q - a_q) >> 1;
    end
  end
endmodule

// File: rtl/pll_cfg_checker.sv
module pll_cfg_checker
  import pll_cfg_pkg::*;
#(
  parameter int CW       = 10,
  parameter int FW       = 16,
  parameter int KD_LIMIT = 500,
  parameter int KM_LIMIT = 1000,
  localparam int KW = 3*CW,
  localparam int PW = FW + 2*CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] m0_i,
  input  logic [CW-1:0] n0_i,
  input  logic [CW-1:0] c0_i,
  input  logic [CW-1:0] m1_i,
  input  logic [CW-1:0] n1_i,
  input  logic [CW-1:0] c1_i,
  input  logic [FW-1:0] fref_i,
  input  logic [FW-1:0] pfd_min_i,
  input  logic [FW-1:0] pfd_max_i,
  input  logic [FW-1:0] vco_min_i,
  input  logic [FW-1:0] vco_max_i,
  input  logic [FW-1:0] out_min_i,
  input  logic [FW-1:0] out_max_i,
  input  logic [FW-1:0] fmax_i,
  output logic          ready_o,
  output logic          done_o,
  output logic          pass_o,
  output logic [3:0]    code_o,
  output logic [KW-1:0] km_o,
  output logic [KW-1:0] kd_o
);
  chk_state_e    state_q;
  fail_code_e    code_q, range_code;
  logic          done_q, pass_q;
  logic [KW-1:0] km_q, kd_q;
  logic [CW-1:0] m_q [2];
  logic [CW-1:0] n_q [2];
  logic [CW-1:0] c_q [2];
  logic [FW-1:0] fref_q, pfd_min_q, pfd_max_q, vco_min_q, vco_max_q;
  logic [FW-1:0] out_min_q, out_max_q, fmax_q;
  logic [1:0]    pfd_ok, vco_ok, out_ok;
  logic          fmax_ok, any_zero, parity_ok;
  logic          gcd_start, gcd_done, gcd_one;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start_i;

  for (genvar i = 0; i < 2; i++) begin : g_pll
    pll_ratio_chk #(.CW(CW), .FW(FW)) u_ratio (
      .m_i       (m_q[i]),
      .n_i       (n_q[i]),
      .c_i       (c_q[i]),
      .fref_i    (fref_q),
      .pfd_min_i (pfd_min_q),
      .pfd_max_i (pfd_max_q),
      .vco_min_i (vco_min_q),
      .vco_max_i (vco_max_q),
      .out_min_i (out_min_q),
      .out_max_i (out_max_q),
      .pfd_ok_o  (pfd_ok[i]),
      .vco_ok_o  (vco_ok[i]),
      .out_ok_o  (out_ok[i])
    );
  end

  // only PLL0 clocks the surrounding logic
  assign fmax_ok = (PW'(fref_q) * PW'(m_q[0])) < (PW'(fmax_q) * PW'(c_q[0]) * PW'(n_q[0]));

  always_comb begin
    any_zero = 1'b0;
    for (int i = 0; i < 2; i++)
      any_zero = any_zero | (m_q[i] == '0) | (n_q[i] == '0) | (c_q[i] == '0);
  end

  assign parity_ok = m_q[0][0] & n_q[1][0] & c_q[1][0];

  // cheapest-first priority
  always_comb begin
    if (any_zero)                     range_code = FC_ZERO;
    else if (!parity_ok)              range_code = FC_PARITY;
    else if (kd_q >= KW'(KD_LIMIT))   range_code = FC_KD;
    else if (km_q >= KW'(KM_LIMIT))   range_code = FC_KM;
    else if (!pfd_ok[0])              range_code = FC_PFD0;
    else if (!vco_ok[0])              range_code = FC_VCO0;
    else if (!out_ok[0])              range_code = FC_OUT0;
    else if (!pfd_ok[1])              range_code = FC_PFD1;
    else if (!vco_ok[1])              range_code = FC_VCO1;
    else if (!out_ok[1])              range_code = FC_OUT1;
    else if (!fmax_ok)                range_code = FC_FMAX;
    else                              range_code = FC_OK;
  end

  assign gcd_start = (state_q == ST_RANGE) && (range_code == FC_OK);

  pll_gcd_unit #(.W(KW)) u_gcd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (gcd_start),
    .a_i     (km_q),
    .b_i     (kd_q),
    .done_o  (gcd_done),
    .one_o   (gcd_one)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      code_q    <= FC_OK;
      km_q      <= '0;
      kd_q      <= '0;
      m_q[0]    <= '0;  m_q[1] <= '0;
      n_q[0]    <= '0;  n_q[1] <= '0;
      c_q[0]    <= '0;  c_q[1] <= '0;
      fref_q    <= '0;
      pfd_min_q <= '0;  pfd_max_q <= '0;
      vco_min_q <= '0;  vco_max_q <= '0;
      out_min_q <= '0;  out_max_q <= '0;
      fmax_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          m_q[0]    <= m0_i;  n_q[0] <= n0_i;  c_q[0] <= c0_i;
          m_q[1]    <= m1_i;  n_q[1] <= n1_i;  c_q[1] <= c1_i;
          km_q      <= KW'(m1_i) * KW'(n0_i) * KW'(c0_i);
          kd_q      <= KW'(m0_i) * KW'(n1_i) * KW'(c1_i);
          fref_q    <= fref_i;
          pfd_min_q <= pfd_min_i;  pfd_max_q <= pfd_max_i;
          vco_min_q <= vco_min_i;  vco_max_q <= vco_max_i;
          out_min_q <= out_min_i;  out_max_q <= out_max_i;
          fmax_q    <= fmax_i;
          state_q   <= ST_RANGE;
        end
        ST_RANGE: begin
          if (range_code != FC_OK) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b0;
            code_q  <= range_code;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_GCD;
          end
        end
        ST_GCD: if (gcd_done) begin
          done_q  <= 1'b1;
          pass_q  <= gcd_one;
          code_q  <= gcd_one ? FC_OK : FC_GCD;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign pass_o  = pass_q;
  assign code_o  = code_q;
  assign km_o    = km_q;
  assign kd_o    = kd_q;
endmodule

// File: rtl/pll_cfg_checker_sva.sv
module pll_cfg_checker_sva #(
  parameter int KW       = 30,
  parameter int KD_LIMIT = 500,
  parameter int KM_LIMIT = 1000,
  localparam int MAX_BUSY = 2*KW + 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ready_o,
  input logic          done_o,
  input logic          pass_o,
  input logic [3:0]    code_o,
  input logic [KW-1:0] km_o,
  input logic [KW-1:0] kd_o
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      busy_cnt <= 0;
    else if (ready_o) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  // R1
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && start_i |=> !ready_o);
  // R1
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(km_o) && $stable(kd_o));
  // R4
  odd_kd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> kd_o[0]);
  // R5
  limits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && pass_o |-> (kd_o < KW'(KD_LIMIT)) && (km_o < KW'(KM_LIMIT)));
  // R9
  code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> code_o <= 4'd12);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  pass_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (code_o == 4'd0)) && ready_o);
  // R11
  busy_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= MAX_BUSY);
endmodule

bind pll_cfg_checker pll_cfg_checker_sva #(
  .KW(KW), .KD_LIMIT(KD_LIMIT), .KM_LIMIT(KM_LIMIT)
) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .pass_o  (pass_o),
  .code_o  (code_o),
  .km_o    (km_o),
  .kd_o    (kd_o)
);

// File: tb/sim_pll_cfg_checker.sv
module sim_pll_cfg_checker;
  localparam int CW = 10;
  localparam int FW = 16;
  localparam int KW = 3*CW;
  localparam int MAX_LAT = 2*KW + 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] m0, n0, c0, m1, n1, c1;
  logic [FW-1:0] fref, pfd_min, pfd_max, vco_min, vco_max, out_min, out_max, fmax;
  logic ready, done, pass;
  logic [3:0] code;
  logic [KW-1:0] km, kd;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10ns clk = ~clk;

  pll_cfg_checker #(.CW(CW), .FW(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .m0_i(m0), .n0_i(n0), .c0_i(c0), .m1_i(m1), .n1_i(n1), .c1_i(c1),
    .fref_i(fref), .pfd_min_i(pfd_min), .pfd_max_i(pfd_max),
    .vco_min_i(vco_min), .vco_max_i(vco_max), .out_min_i(out_min), .out_max_i(out_max),
    .fmax_i(fmax), .ready_o(ready), .done_o(done), .pass_o(pass), .code_o(code),
    .km_o(km), .kd_o(kd));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint gcd_f(longint a, longint b);
    longint t;
    while (b != 0) begin t = a % b; a = b; b = t; end
    return a;
  endfunction

  // expected code from the requirement list
  function automatic int ref_code(longint a0, longint b0, longint d0, longint a1, longint b1, longint d1);
    longint f = fref, kmv = a1*b0*d0, kdv = a0*b1*d1;
    longint mm[2], nn[2], cc[2];
    mm[0] = a0; nn[0] = b0; cc[0] = d0; mm[1] = a1; nn[1] = b1; cc[1] = d1;
    if (a0 == 0 || b0 == 0 || d0 == 0 || a1 == 0 || b1 == 0 || d1 == 0) return 1;
    if (a0 % 2 == 0 || b1 % 2 == 0 || d1 % 2 == 0) return 2;
    if (kdv >= 500) return 3;
    if (kmv >= 1000) return 4;
    for (int i = 0; i < 2; i++) begin
      if (!(longint'(pfd_min)*nn[i] < f && f < longint'(pfd_max)*nn[i])) return 5 + 3*i;
      if (!(longint'(vco_min)*nn[i] < f*mm[i] && f*mm[i] < longint'(vco_max)*nn[i])) return 6 + 3*i;
      if (!(longint'(out_min)*nn[i]*cc[i] < f*mm[i] && f*mm[i] < longint'(out_max)*nn[i]*cc[i])) return 7 + 3*i;
    end
    if (!(f*a0 < longint'(fmax)*d0*b0)) return 11;
    if (gcd_f(kmv, kdv) != 1) return 12;
    return 0;
  endfunction

  task automatic run(input int a0, b0, d0, a1, b1, d1, output int lat);
    @(negedge clk);
    m0 = CW'(a0); n0 = CW'(b0); c0 = CW'(d0); m1 = CW'(a1); n1 = CW'(b1); c1 = CW'(d1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 200);
  endtask

  // full check of one candidate against the model
  task automatic check_cand(input int a0, b0, d0, a1, b1, d1, input string req);
    int lat, e;
    e = ref_code(a0, b0, d0, a1, b1, d1);
    run(a0, b0, d0, a1, b1, d1, lat);
    chk(done && code == 4'(e) && pass == (e == 0), req, code, e);
    chk(km == KW'(a1*b0*d0) && kd == KW'(a0*b1*d1), "R2", km, a1*b0*d0);
    if (e >= 1 && e <= 11) chk(lat == 1, "R10 latency", lat, 1);
    else                   chk(lat >= 2 && lat <= MAX_LAT, "R11 latency", lat, MAX_LAT);
  endtask

  task automatic wide_limits();
    pfd_min = '0; pfd_max = '1; vco_min = '0; vco_max = '1;
    out_min = '0; out_max = '1; fmax = '1;
  endtask

  initial begin
    #(200000 * 20ns);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    {m0, n0, c0, m1, n1, c1} = '0;
    fref = 16'd1; wide_limits();
    repeat (3) @(negedge clk);
    chk(ready === 1'b1 && done === 1'b0, "R1 reset", {ready, done}, 2);
    rst_n = 1'b1;

    // sweep of a small coefficient space
    fref = 16'd24; pfd_min = 16'd9; pfd_max = 16'd30; vco_min = 16'd10; vco_max = 16'd60;
    out_min = 16'd3; out_max = 16'd40; fmax = 16'd30;
    for (int a0 = 0; a0 <= 5; a0++)
      for (int b0 = 1; b0 <= 3; b0++)
        for (int d0 = 1; d0 <= 3; d0++)
          for (int a1 = 1; a1 <= 4; a1++)
            for (int b1 = 1; b1 <= 3; b1++)
              for (int d1 = 1; d1 <= 3; d1++)
                check_cand(a0, b0, d0, a1, b1, d1, "R3 R4 R6 R7 R8 R9 sweep");

    // R5 boundaries
    fref = 16'd1; wide_limits();
    check_cand(499, 1, 1, 1, 1, 1, "R5 kd=499");
    check_cand(501, 1, 1, 1, 1, 1, "R5 kd=501");
    check_cand(1, 1, 1, 999, 1, 1, "R5 km=999");
    check_cand(1, 1, 1, 1000, 1, 1, "R5 km=1000");
    // R6 strict lower bound on pfd
    fref = 16'd20; pfd_min = 16'd10;
    check_cand(3, 2, 1, 1, 1, 1, "R6 pfd equal");
    // R8 strict fmax, PLL1 not bound by it
    wide_limits(); fmax = 16'd30;
    check_cand(3, 1, 2, 5, 1, 1, "R8 out0=fmax");
    fmax = 16'd31;
    check_cand(3, 1, 2, 5, 1, 1, "R8 out1 above fmax");
    chk(code == 4'd0, "R8 pll1 unbound", code, 0);
    // R9 and R10 priority
    wide_limits();
    check_cand(3, 1, 1, 3, 1, 1, "R9 gcd");
    check_cand(2, 1, 1, 2, 1, 1, "R10 parity over gcd");
    check_cand(0, 2, 1, 1, 1, 1, "R10 zero over parity");
    check_cand(1, 1, 1, 1, 1, 1, "R9 minimal pass");

    // R1 start ignored while busy
    fref = 16'd1; wide_limits();
    @(negedge clk);
    m0 = 10'd499; n0 = 10'd1; c0 = 10'd1; m1 = 10'd997; n1 = 10'd1; c1 = 10'd1;
    start = 1'b1;
    @(negedge clk);
    m0 = 10'd7; m1 = 10'd3;
    repeat (2) @(negedge clk);
    chk(ready == 1'b0, "R1 busy", ready, 0);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk(done && km == 30'd997 && kd == 30'd499 && pass, "R1 ignore busy start", km, 997);
    lat = 0;
    repeat (5) begin @(negedge clk); if (done) lat++; end
    chk(lat == 0 && ready, "R1 no second result", lat, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule